// File: doc/BRIEF.md
# Interrupt Priority Threshold Arbiter

This block picks, for one interrupt target context, the single best interrupt among a set of numbered sources. A source can win only if it is pending, enabled for the context and has a non-zero priority. Among the sources that qualify, the highest priority wins. When several share that priority, the one with the smallest source number wins. Source number 0 is reserved and never exists. The block drives the winning source number and its priority. An output of zero means nothing qualifies.

A separate request line to the context is raised when the winning priority is strictly greater than the context's threshold. The threshold affects only that line. The selected source number still reports the best candidate, so a claim path can read it at any time. The block is purely combinational. Priority storage, the register interface and the claim/complete side effects belong to the surrounding logic. The inputs carry no handshake: the outputs always reflect the current inputs, so there is no back-pressure to manage.

Internally, each source is first reduced to an (effective priority, number) pair. A balanced binary tree of compare-select nodes then reduces these pairs. Each node keeps its lower-numbered operand unless the other operand's priority is strictly larger.

Top module: `irq_prio_arbiter`

## Requirements
- R1: Source number 0 is never selected. When no source qualifies, `claim_id` is 0 and `max_prio` is 0.
- R2: A source with priority 0 never wins, even when it is pending and enabled.
- R3: A source wins only when its pending bit and its enable bit are both 1.
- R4: `max_prio` equals the largest priority among the qualifying sources, and `claim_id` names a qualifying source with that priority.
- R5: When qualifying sources tie at the top priority, `claim_id` is the numerically lowest of them.
- R6: `irq` is 1 exactly when `max_prio` is strictly greater than `threshold`. A threshold of 0 passes any non-zero priority, and a priority equal to the threshold is masked.
- R7: `claim_id` and `max_prio` do not depend on `threshold`.
- R8: The highest level, 2^PRIO_W-1, is handled like any other level. A threshold at that level keeps `irq` at 0 for every input.
- R9: The outputs are a combinational function of the inputs. They settle in the same cycle in which an input changes, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_prio | input | NSRC*PRIO_W | Priority of each source. Element i holds the priority of source i, for i from 1 to NSRC. |
| src_pending | input | NSRC | Pending flag of each source. Bit i belongs to source i. |
| src_enable | input | NSRC | The context's enable flag for each source. Bit i belongs to source i. |
| threshold | input | PRIO_W | The context's threshold. Priorities at or below it do not raise `irq`. |
| claim_id | output | $clog2(NSRC+1) | Number of the winning source, or 0 when no source qualifies. |
| max_prio | output | PRIO_W | Priority of the winning source, or 0 when no source qualifies. |
| irq | output | 1 | Interrupt request to the context. |

## Verification
The bench builds the block with NSRC = 37 and PRIO_W = 3. Thirty-seven sources is not a power of two, so the tree contains padded leaves that must never win. Source 37, the last real leaf, sits next to that padding and is tested on its own. Three priority bits give only seven active levels. With random stimulus this makes ties frequent, so the lowest-number rule gets exercised, and it also lets a short sweep cover every threshold value, including the top level 7.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int unsigned MAX_SOURCES = 1023;

  // Smallest power of two not below n (n >= 1).
  function automatic int unsigned pow2_ceil(input int unsigned n);
    int unsigned r;
    r = 1;
    while (r < n) r = r << 1;
    return r;
  endfunction

endpackage

// File: rtl/prio_leaf.sv
module prio_leaf #(
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ID_W   = 5,
  parameter int unsigned SRC_NO = 1
) (
  input  logic [PRIO_W-1:0] prio,
  input  logic              pend,
  input  logic              en,
  output logic [PRIO_W-1:0] eff_prio,
  output logic [ID_W-1:0]   eff_id
);
  logic ok;

  always_comb begin
    ok       = pend && en && (prio != '0);
    eff_prio = ok ? prio : '0;
    eff_id   = ok ? ID_W'(SRC_NO) : '0;
  end

  always_comb begin
    // R2
    leaf_zero_prio_chk: assert (prio != '0 || (eff_prio == '0 && eff_id == '0));
    // R3
    leaf_needs_pend_en_chk: assert ((pend && en) || eff_id == '0);
  end
endmodule

// File: rtl/prio_node.sv
module prio_node #(
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ID_W   = 5
) (
  input  logic [PRIO_W-1:0] lo_prio,
  input  logic [ID_W-1:0]   lo_id,
  input  logic [PRIO_W-1:0] hi_prio,
  input  logic [ID_W-1:0]   hi_id,
  output logic [PRIO_W-1:0] out_prio,
  output logic [ID_W-1:0]   out_id
);
  logic take_hi;

  always_comb begin
    // Strict compare: on equal priority the lower-numbered side stays.
    take_hi  = hi_prio > lo_prio;
    out_prio = take_hi ? hi_prio : lo_prio;
    out_id   = take_hi ? hi_id   : lo_id;
  end

  always_comb begin
    // R4
    node_keeps_max_chk: assert (out_prio >= lo_prio && out_prio >= hi_prio);
    // R5
    node_tie_low_chk: assert (lo_prio != hi_prio || out_id == lo_id);
  end
endmodule

// File: rtl/prio_tree.sv
module prio_tree #(
  parameter int unsigned NSRC   = 31,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ID_W   = 5
) (
  input  logic [NSRC:1][PRIO_W-1:0] prio,
  input  logic [NSRC:1]             pend,
  input  logic [NSRC:1]             en,
  output logic [PRIO_W-1:0]         best_prio,
  output logic [ID_W-1:0]           best_id
);
  localparam int unsigned LEAVES = irq_arb_pkg::pow2_ceil(NSRC);
  localparam int unsigned LVLS   = $clog2(LEAVES);

  for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
    localparam int unsigned CNT = LEAVES >> l;
    logic [PRIO_W-1:0] p [CNT];
    logic [ID_W-1:0]   d [CNT];
    if (l == 0) begin : g_leaves
      for (genvar i = 0; i < CNT; i++) begin : g_leaf
        if (i < NSRC) begin : g_real
          prio_leaf #(.PRIO_W(PRIO_W), .ID_W(ID_W), .SRC_NO(i + 1)) i_leaf (
            .prio(prio[i+1]), .pend(pend[i+1]), .en(en[i+1]),
            .eff_prio(p[i]), .eff_id(d[i])
          );
        end else begin : g_pad
          assign p[i] = '0;
          assign d[i] = '0;
        end
      end
    end else begin : g_nodes
      for (genvar k = 0; k < CNT; k++) begin : g_node
        prio_node #(.PRIO_W(PRIO_W), .ID_W(ID_W)) i_node (
          .lo_prio(g_lvl[l-1].p[2*k]),   .lo_id(g_lvl[l-1].d[2*k]),
          .hi_prio(g_lvl[l-1].p[2*k+1]), .hi_id(g_lvl[l-1].d[2*k+1]),
          .out_prio(p[k]), .out_id(d[k])
        );
      end
    end
  end

  assign best_prio = g_lvl[LVLS].p[0];
  assign best_id   = g_lvl[LVLS].d[0];

  always_comb begin
    for (int i = 1; i <= int'(NSRC); i++) begin
      // R4
      tree_root_max_chk: assert (!(pend[i] && en[i]) || best_prio >= prio[i]);
    end
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
  parameter int unsigned NSRC   = 31,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned ID_W  = $clog2(NSRC + 1)
) (
  input  logic [NSRC:1][PRIO_W-1:0] src_prio,
  input  logic [NSRC:1]             src_pending,
  input  logic [NSRC:1]             src_enable,
  input  logic [PRIO_W-1:0]         threshold,
  output logic [ID_W-1:0]           claim_id,
  output logic [PRIO_W-1:0]         max_prio,
  output logic                      irq
);
  initial begin
    if (NSRC < 1 || NSRC > irq_arb_pkg::MAX_SOURCES)
      $error("NSRC out of range");
  end

  prio_tree #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) i_tree (
    .prio(src_prio), .pend(src_pending), .en(src_enable),
    .best_prio(max_prio), .best_id(claim_id)
  );

  // Threshold compare gates only the request, never the selection.
  assign irq = max_prio > threshold;

  always_comb begin
    // R1
    idle_zero_chk: assert ((claim_id == '0) == (max_prio == '0));
    // R4
    winner_valid_chk: assert (claim_id == '0 ||
      (claim_id <= ID_W'(NSRC) && src_pending[claim_id] && src_enable[claim_id] &&
       src_prio[claim_id] == max_prio));
    // R6
    irq_has_winner_chk: assert (!irq || claim_id != '0);
  end
endmodule

// File: tb/test_irq_prio_arbiter.sv
module test_irq_prio_arbiter;
  localparam int unsigned NSRC   = 37;
  localparam int unsigned PRIO_W = 3;
  localparam int unsigned ID_W   = $clog2(NSRC + 1);
  localparam int unsigned PMAX   = (1 << PRIO_W) - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [NSRC:1][PRIO_W-1:0] src_prio = '0;
  logic [NSRC:1]             src_pending = '0;
  logic [NSRC:1]             src_enable = '0;
  logic [PRIO_W-1:0]         threshold = '0;
  logic [ID_W-1:0]           claim_id;
  logic [PRIO_W-1:0]         max_prio;
  logic                      irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  irq_prio_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) i_irq_prio_arbiter (
    .src_prio(src_prio), .src_pending(src_pending), .src_enable(src_enable),
    .threshold(threshold), .claim_id(claim_id), .max_prio(max_prio), .irq(irq)
  );

  function automatic int ref_id();
    int best = 0, id = 0;
    for (int i = 1; i <= int'(NSRC); i++)
      if (src_pending[i] && src_enable[i] && int'(src_prio[i]) > best) begin
        best = int'(src_prio[i]);
        id = i;
      end
    return id;
  endfunction

  function automatic int ref_prio();
    int id = ref_id();
    return (id == 0) ? 0 : int'(src_prio[id]);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    int e_id = ref_id();
    int e_pr = ref_prio();
    check(req, "claim_id", int'(claim_id), e_id);
    check(req, "max_prio", int'(max_prio), e_pr);
    check(req, "irq", int'(irq), (e_pr > int'(threshold)) ? 1 : 0);
  endtask

  task automatic clear_all();
    @(posedge clk);
    src_prio = '0; src_pending = '0; src_enable = '0; threshold = '0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_1234);
    settle();
    // R1: reset-like idle state with all inputs zero
    check("R1", "idle claim_id", int'(claim_id), 0);
    check("R1", "idle max_prio", int'(max_prio), 0);
    check("R1", "idle irq", int'(irq), 0);

    // R2: pending and enabled but priority 0
    clear_all(); src_pending[5] = 1; src_enable[5] = 1; settle();
    check("R2", "zero prio claim_id", int'(claim_id), 0);
    check_all("R2");

    // R3: pending not enabled, enabled not pending
    clear_all(); src_prio[3] = 6; src_pending[3] = 1;
    src_prio[4] = 5; src_enable[4] = 1;
    src_prio[9] = 1; src_pending[9] = 1; src_enable[9] = 1; settle();
    check("R3", "gated claim_id", int'(claim_id), 9);
    check_all("R3");

    // R5: tie goes to lowest number
    clear_all();
    for (int i = 10; i <= 20; i += 5) begin
      src_prio[i] = 4; src_pending[i] = 1; src_enable[i] = 1;
    end
    src_prio[2] = 3; src_pending[2] = 1; src_enable[2] = 1; settle();
    check("R5", "tie claim_id", int'(claim_id), 10);
    check_all("R5");

    // R6 / R7: sweep threshold over a fixed set of sources
    for (int t = 0; t <= int'(PMAX); t++) begin
      @(posedge clk); threshold = PRIO_W'(t); settle();
      check("R7", "claim_id vs threshold", int'(claim_id), 10);
      check("R7", "max_prio vs threshold", int'(max_prio), 4);
      check("R6", "irq vs threshold", int'(irq), (t < 4) ? 1 : 0);
    end

    // R8: top level with threshold at top; last real source alone
    clear_all(); src_prio[NSRC] = PRIO_W'(PMAX);
    src_pending[NSRC] = 1; src_enable[NSRC] = 1; threshold = PRIO_W'(PMAX - 1); settle();
    check("R8", "top claim_id", int'(claim_id), int'(NSRC));
    check("R8", "top irq at thr max-1", int'(irq), 1);
    @(posedge clk); threshold = PRIO_W'(PMAX); settle();
    check("R8", "top irq at thr max", int'(irq), 0);
    check("R8", "top max_prio", int'(max_prio), int'(PMAX));

    // R9: an input change shows up in the same cycle
    @(posedge clk); src_prio[1] = PRIO_W'(PMAX); src_pending[1] = 1; src_enable[1] = 1;
    #1;
    check("R9", "same-cycle claim_id", int'(claim_id), 1);

    // R4: constrained random against the linear-scan model
    for (int n = 0; n < 3000; n++) begin
      @(posedge clk);
      for (int i = 1; i <= int'(NSRC); i++) begin
        src_prio[i]    = PRIO_W'($urandom_range(0, PMAX));
        src_pending[i] = ($urandom_range(0, 3) != 0);
        src_enable[i]  = ($urandom_range(0, 3) != 0);
      end
      if (n % 4 == 0) src_enable = '0;
      threshold = PRIO_W'($urandom_range(0, PMAX));
      settle();
      check_all("R4");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule